// File: doc/BRIEF.md
# Two-Target Prioritized Interrupt Controller

This block gathers interrupt requests from a parameterized set of sources and hands the most urgent one to one of two processors. The low-numbered sources are raised and cleared by register writes from software. The rest are level-sensitive hardware inputs. Each source has a 4-bit priority and a one-bit target that steers it to processor 0 or processor 1. A priority of zero disables the source. Each processor sees a registered request line and the 9-bit vector of the winning source. The vector is a fixed base plus the source index, so every source has a different vector.

Each processor has a current-priority level. A request is presented only if its priority is strictly above that level. Software can write the level directly, for example to raise it to a ceiling while it holds a shared resource. When a processor acknowledges a presented request, the block does two things: it saves the old level on a small per-processor stack and raises the level to the priority it has just served. An end-of-interrupt pulse restores the saved level. While a processor's stack is full, nothing is presented to that processor.

Top module: `intc_steer`

## Requirements
- R1: After reset, every source's priority and target read as 0. Both current levels read 0. The software pending register reads 0. Both request lines are low.
- R2: When a source wins, its processor's vector output carries VEC_BASE plus the source index (default 256 + index) while the request line is high.
- R3: A source whose priority is 0 is never presented, even while it is pending.
- R4: Among the eligible sources steered to a processor, the one with the highest priority is presented. Among equal priorities, the lowest source index wins.
- R5: Target bit 0 steers a source to processor 0, and 1 steers it to processor 1. A source never raises the other processor's request.
- R6: A source is presented only if its priority is strictly greater than the current level of its processor. Software sets processor c's current level by writing address 0x40+c, with the level in bits 3:0, and reads it back at the same address.
- R7: An acknowledge while the request is high does three things: it pushes the current level, sets the level to the served priority, and drops the request at that same clock edge.
- R8: An end-of-interrupt pops the stack and restores the saved level. With an empty stack it leaves the level unchanged. If acknowledge and end-of-interrupt arrive together, the end-of-interrupt is honoured and the acknowledge is ignored.
- R9: While a processor's stack holds STACK_DEPTH entries (default 4), no request is presented to that processor. The request reappears once an end-of-interrupt frees an entry.
- R10: Writing a mask to address 0x50 sets software sources 0..N_SW-1 pending. They stay pending across acknowledge and end-of-interrupt until a mask is written to 0x51, which clears them. Address 0x50 reads back the pending bits. A hardware source is pending only while its input is high.
- R11: The source configuration register is at address i, for i below N_SRC. Bits 3:0 hold the priority and bit 4 holds the target. It reads back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | N_SRC-N_SW | Level requests; bit k is source N_SW+k |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on reg_addr |
| irq_req | output | 2 | Request line per processor |
| irq_vec | output | 2*VEC_W | Vector per processor; processor c at bits c*VEC_W upward |
| irq_ack | input | 2 | Acknowledge pulse per processor |
| irq_eoi | input | 2 | End-of-interrupt pulse per processor |

## Verification
The bench sweeps every source across both targets, a range of priorities and every current-level value. A steering fault would raise the wrong processor's line. An off-by-one in the level comparison would present a request at exactly the current level. The bench places equal priorities on neighbouring sources, so a reversed or unstable tie-break would show the higher index. Nested acknowledges fill the stack to its depth. A design that let an extra acknowledge through would present a request while full, or restore the wrong level when the stack unwinds. The bench also checks that a software source comes back after end-of-interrupt and that a stray end-of-interrupt on an empty stack leaves the level unchanged.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int NUM_CPU     = 2;
   localparam int CUR_BASE    = 'h40;
   localparam int SW_SET_ADDR = 'h50;
   localparam int SW_CLR_ADDR = 'h51;
endpackage

// File: rtl/intc_arbiter.sv
// Linear scan: a later source replaces the current winner only with a strictly higher priority
module intc_arbiter #(
   parameter int N_SRC  = 16,
   parameter int PRIO_W = 4,
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]        elig,
   input  logic [N_SRC*PRIO_W-1:0] prio_flat,
   output logic                    found,
   output logic [IDX_W-1:0]        win_idx,
   output logic [PRIO_W-1:0]       win_prio
);
   always_comb begin
      found    = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (elig[i] && (prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
            found    = 1'b1;
            win_idx  = IDX_W'(i);
            win_prio = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/intc_cpu_ctx.sv
module intc_cpu_ctx #(
   parameter int N_SRC       = 16,
   parameter int PRIO_W      = 4,
   parameter int VEC_W       = 9,
   parameter int VEC_BASE    = 256,
   parameter int STACK_DEPTH = 4,
   localparam int IDX_W      = $clog2(N_SRC),
   localparam int SP_W       = $clog2(STACK_DEPTH + 1),
   localparam int STK_IW     = $clog2(STACK_DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SRC-1:0]        cand,
   input  logic [N_SRC*PRIO_W-1:0] prio_flat,
   input  logic                    ack,
   input  logic                    eoi,
   input  logic                    cur_we,
   input  logic [PRIO_W-1:0]       cur_wdata,
   output logic                    req,
   output logic [VEC_W-1:0]        vec,
   output logic [PRIO_W-1:0]       cur
);
   logic [N_SRC-1:0]  elig;
   logic              found;
   logic [IDX_W-1:0]  win_idx;
   logic [PRIO_W-1:0] win_prio;
   logic              req_q;
   logic [VEC_W-1:0]  vec_q;
   logic [PRIO_W-1:0] wp_q, cur_q, top_val;
   logic [SP_W-1:0]   sp;
   logic [SP_W-1:0]   sp_m1;
   logic [PRIO_W-1:0] stk [STACK_DEPTH];
   logic              full, take, pop;

   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      assign elig[i] = cand[i] && (prio_flat[i*PRIO_W +: PRIO_W] > cur_q);
   end

   intc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
      .elig(elig), .prio_flat(prio_flat),
      .found(found), .win_idx(win_idx), .win_prio(win_prio)
   );

   assign full    = (sp == SP_W'(STACK_DEPTH));
   assign take    = ack && req_q && !eoi && !full;
   assign pop     = eoi && (sp != '0);
   assign sp_m1   = sp - 1'b1;
   assign top_val = stk[sp_m1[STK_IW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         vec_q <= '0;
         wp_q  <= '0;
         cur_q <= '0;
         sp    <= '0;
      end else begin
         if (pop) begin
            cur_q <= top_val;
            sp    <= sp_m1;
         end else if (take) begin
            cur_q <= wp_q;
            sp    <= sp + 1'b1;
         end else if (cur_we) begin
            cur_q <= cur_wdata;
         end
         req_q <= found && !full && !take;
         vec_q <= found ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : '0;
         wp_q  <= found ? win_prio : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (take) stk[sp[STK_IW-1:0]] <= cur_q;
   end

   assign req = req_q;
   assign vec = vec_q;
   assign cur = cur_q;

   a_r7_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && req_q && !eoi) |=> (cur_q == $past(wp_q)) && !req_q);
   a_r8_eoi_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && sp != '0) |=> cur_q == $past(top_val));
   a_r8_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && sp == '0 && !cur_we) |=> $stable(cur_q));
   a_r9_no_req_full: assert property (@(posedge clk) disable iff (!rst_n)
      (sp == SP_W'(STACK_DEPTH)) |=> !req_q);
   a_r9_sp_bound: assert property (@(posedge clk) disable iff (!rst_n)
      sp <= SP_W'(STACK_DEPTH));
   a_r6_above_cur: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> wp_q > $past(cur_q));
   a_r2_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> (vec_q >= VEC_W'(VEC_BASE)) && (vec_q < VEC_W'(VEC_BASE + N_SRC)));
endmodule

// File: rtl/intc_steer.sv
module intc_steer
   import intc_pkg::*;
#(
   parameter int N_SRC       = 16,
   parameter int N_SW        = 8,
   parameter int PRIO_W      = 4,
   parameter int VEC_W       = 9,
   parameter int VEC_BASE    = 256,
   parameter int STACK_DEPTH = 4,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   localparam int N_HW       = N_SRC - N_SW
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_HW-1:0]            hw_irq,
   input  logic                       reg_we,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   output logic [NUM_CPU-1:0]         irq_req,
   output logic [NUM_CPU*VEC_W-1:0]   irq_vec,
   input  logic [NUM_CPU-1:0]         irq_ack,
   input  logic [NUM_CPU-1:0]         irq_eoi
);
   if (N_SW < 1 || N_SW >= N_SRC) begin : g_chk_sw
      $error("N_SW must lie in 1..N_SRC-1");
   end
   if (N_SW > DATA_W || PRIO_W + 1 > DATA_W) begin : g_chk_dw
      $error("DATA_W too narrow for pending mask or config field");
   end
   if (VEC_BASE + N_SRC > (1 << VEC_W)) begin : g_chk_vec
      $error("vectors do not fit VEC_W");
   end
   if (N_SRC > CUR_BASE || STACK_DEPTH < 2) begin : g_chk_map
      $error("source count overlaps register map or stack too shallow");
   end

   logic [PRIO_W-1:0]       prio_r [N_SRC];
   logic [N_SRC-1:0]        tgt_r;
   logic [N_SW-1:0]         sw_pend;
   logic [N_SRC-1:0]        pend;
   logic [N_SRC*PRIO_W-1:0] prio_flat;
   logic [PRIO_W-1:0]       cur_o [NUM_CPU];
   logic                    set_wr, clr_wr;

   assign set_wr = reg_we && (reg_addr == ADDR_W'(SW_SET_ADDR));
   assign clr_wr = reg_we && (reg_addr == ADDR_W'(SW_CLR_ADDR));

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (i < N_SW) begin : g_sw
         assign pend[i] = sw_pend[i];
      end else begin : g_hw
         assign pend[i] = hw_irq[i - N_SW];
      end
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_r[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_r   <= '0;
         sw_pend <= '0;
         for (int i = 0; i < N_SRC; i++) prio_r[i] <= '0;
      end else begin
         for (int i = 0; i < N_SRC; i++) begin
            if (reg_we && reg_addr == ADDR_W'(i)) begin
               prio_r[i] <= reg_wdata[PRIO_W-1:0];
               tgt_r[i]  <= reg_wdata[PRIO_W];
            end
         end
         if (set_wr)      sw_pend <= sw_pend | reg_wdata[N_SW-1:0];
         else if (clr_wr) sw_pend <= sw_pend & ~reg_wdata[N_SW-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (reg_addr == ADDR_W'(i)) reg_rdata = DATA_W'({tgt_r[i], prio_r[i]});
      end
      for (int c = 0; c < NUM_CPU; c++) begin
         if (reg_addr == ADDR_W'(CUR_BASE + c)) reg_rdata = DATA_W'(cur_o[c]);
      end
      if (reg_addr == ADDR_W'(SW_SET_ADDR)) reg_rdata = DATA_W'(sw_pend);
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [N_SRC-1:0] cand;
      for (genvar i = 0; i < N_SRC; i++) begin : g_cand
         assign cand[i] = pend[i] && (prio_r[i] != '0) && (tgt_r[i] == 1'(c));
      end
      intc_cpu_ctx #(
         .N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W),
         .VEC_BASE(VEC_BASE), .STACK_DEPTH(STACK_DEPTH)
      ) u_ctx (
         .clk(clk), .rst_n(rst_n), .cand(cand), .prio_flat(prio_flat),
         .ack(irq_ack[c]), .eoi(irq_eoi[c]),
         .cur_we(reg_we && reg_addr == ADDR_W'(CUR_BASE + c)),
         .cur_wdata(reg_wdata[PRIO_W-1:0]),
         .req(irq_req[c]), .vec(irq_vec[c*VEC_W +: VEC_W]), .cur(cur_o[c])
      );
   end

   a_r10_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (sw_pend & $past(reg_wdata[N_SW-1:0])) == '0);
   a_r10_sw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (sw_pend & $past(sw_pend)) == $past(sw_pend));
endmodule

// File: tb/sim_intc_steer.sv
module sim_intc_steer;
   localparam int VW = 9;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  hw_irq = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [1:0]  irq_req;
   logic [17:0] irq_vec;
   logic [1:0]  irq_ack = '0;
   logic [1:0]  irq_eoi = '0;
   int checks = 0;
   int failures = 0;

   intc_steer u0 (
      .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_eoi(irq_eoi)
   );

   always #5 clk = ~clk;

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_addr = 8'(a);
      #1;
      d = int'(reg_rdata);
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic trig(input int i, input bit on);
      if (i < 8) wr(on ? 'h50 : 'h51, 1 << i);
      else hw_irq[i-8] = on;
   endtask

   task automatic pulse_ack(input int c);
      @(negedge clk); irq_ack[c] = 1'b1;
      @(negedge clk); irq_ack[c] = 1'b0;
   endtask

   task automatic pulse_eoi(input int c);
      @(negedge clk); irq_eoi[c] = 1'b1;
      @(negedge clk); irq_eoi[c] = 1'b0;
   endtask

   function automatic int vec_of(input int c);
      return int'(irq_vec[c*VW +: VW]);
   endfunction

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 req", int'(irq_req), 0);
      for (int i = 0; i < 16; i++) begin rd(i, v); chk("R1 cfg", v, 0); end
      rd('h40, v); chk("R1 cur0", v, 0);
      rd('h41, v); chk("R1 cur1", v, 0);
      rd('h50, v); chk("R1 swpend", v, 0);

      // R2 R5 R11 sweep over every source and both targets
      for (int i = 0; i < 16; i++) begin
         for (int t = 0; t < 2; t++) begin
            int p = 1 + (i % 15);
            wr(i, (t << 4) | p);
            rd(i, v); chk("R11 cfg readback", v, (t << 4) | p);
            trig(i, 1'b1);
            settle();
            chk("R5 req target", int'(irq_req[t]), 1);
            chk("R5 other idle", int'(irq_req[1-t]), 0);
            chk("R2 vector", vec_of(t), 256 + i);
            trig(i, 1'b0);
            wr(i, 0);
            settle();
            chk("R10 withdrawn", int'(irq_req), 0);
         end
      end

      // R3 priority zero disables
      wr('h50, 'hFF); hw_irq = 8'hFF;
      settle();
      chk("R3 all disabled", int'(irq_req), 0);

      // R4 highest priority then lowest index on ties
      for (int i = 0; i < 16; i++) wr(i, 5);
      settle();
      chk("R4 tie all", vec_of(0), 256);
      for (int i = 0; i < 16; i++) begin
         wr(i, 9); settle();
         chk("R4 highest", vec_of(0), 256 + i);
         if (i < 15) begin
            wr(i + 1, 9); settle();
            chk("R4 tie lower index", vec_of(0), 256 + i);
            wr(i + 1, 5);
         end
         wr(i, 5);
      end
      for (int i = 0; i < 16; i++) wr(i, 0);
      wr('h51, 'hFF); hw_irq = '0;

      // R6 current level sweep on processor 1
      wr(12, 'h17); hw_irq[4] = 1'b1;
      for (int c = 0; c < 16; c++) begin
         wr('h41, c); settle();
         chk("R6 strict above", int'(irq_req[1]), (7 > c) ? 1 : 0);
         rd('h41, v); chk("R6 cur readback", v, c);
      end
      wr('h41, 0); hw_irq[4] = 1'b0; wr(12, 0);

      // R7 R8 R10 nesting on processor 0
      wr(0, 3); trig(0, 1'b1); settle();
      chk("R2 sw0 vec", vec_of(0), 256);
      pulse_ack(0);
      chk("R7 req drops", int'(irq_req[0]), 0);
      rd('h40, v); chk("R7 cur raised", v, 3);
      settle();
      chk("R6 equal masked", int'(irq_req[0]), 0);
      rd('h50, v); chk("R10 sw still pending", v & 1, 1);
      wr(9, 6); hw_irq[1] = 1'b1; settle();
      chk("R7 nested vec", vec_of(0), 265);
      pulse_ack(0);
      rd('h40, v); chk("R7 cur nested", v, 6);
      pulse_eoi(0);
      rd('h40, v); chk("R8 pop", v, 3);
      settle();
      chk("R10 hw level re-presented", vec_of(0), 265);
      hw_irq[1] = 1'b0; settle();
      chk("R10 hw level withdrawn", int'(irq_req[0]), 0);
      pulse_eoi(0);
      rd('h40, v); chk("R8 pop to zero", v, 0);
      settle();
      chk("R10 sw back after eoi", vec_of(0), 256);
      pulse_eoi(0);
      rd('h40, v); chk("R8 empty eoi ignored", v, 0);
      wr('h51, 1); settle();
      chk("R10 cleared", int'(irq_req[0]), 0);
      rd('h50, v); chk("R10 pend readback", v, 0);
      wr(0, 0); wr(9, 0);

      // R9 stack full blocks presentation
      wr('h50, 'h3E);
      for (int k = 1; k <= 4; k++) begin
         wr(k, 2 * k); settle();
         chk("R9 fill vec", vec_of(0), 256 + k);
         pulse_ack(0);
      end
      rd('h40, v); chk("R9 cur at full", v, 8);
      wr(5, 10); settle();
      chk("R9 full blocks", int'(irq_req[0]), 0);
      pulse_eoi(0);
      rd('h40, v); chk("R9 pop restores", v, 6);
      settle();
      chk("R9 presented after pop", int'(irq_req[0]), 1);
      chk("R9 vec after pop", vec_of(0), 261);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule